// File: doc/BRIEF.md
# SDRAM Command and Address Decoder

This block is the command front end inside a four-bank synchronous DRAM device. On every rising clock edge it samples clock enable, chip select, the three active-low strobes (row strobe, column strobe, write enable), a 13-bit address and a 2-bit bank address. It turns each accepted command into a single registered event. The event carries the command kind, a mask of the banks it touches, a row address, a column address, an auto-precharge flag and an error flag.

The decoder also keeps a record of which banks hold an open row and which row that is. Read and write events report the row open in their bank. The error flag goes high for an access to a closed bank and for an activate to a bank that is already open. The parameter `ORG` (4, 8 or 16, the data width of the device) sets how many address bits form the column address.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: While `rstN` is low, and after it is released, `cmdValid`, `cmdType`, `bankMask`, `rowAddr`, `colAddr`, `autoPre` and `cmdError` are all zero, and `openMask` is 0000. Every bank is then closed and its stored row is zero.
- R2: A command is accepted when `cke` is high and `csN` is low at a rising edge. `{rasN,casN,weN}` selects the kind, reported on `cmdType`: 111 no-op (0), 011 activate (1), 101 read (2), 100 write (3), 010 precharge (4), 001 auto-refresh (5), 000 mode-register set (6). The pattern 110 produces no event. No-op, auto-refresh and mode-register set report a zero bank mask, and mode-register set puts the sampled address on `rowAddr`.
- R3: When `csN` is high or `cke` is low at an edge, no event is produced and `openMask` keeps its value.
- R4: An activate reports the sampled address on `rowAddr` and a one-hot `bankMask` (bit n for bank n). When the bank was closed, the bank is opened and that row is stored for it.
- R5: Read and write report a one-hot `bankMask`, and `rowAddr` carries the row stored for that bank. `colAddr` is addr[8:0] for `ORG`=16, addr[9:0] for `ORG`=8, and {addr[11], addr[9:0]} for `ORG`=4.
- R6: On a read or write, address bit 10 appears on `autoPre`. When it is high and the bank is open, the bank is closed and its stored row is cleared.
- R7: On a precharge with address bit 10 high, `bankMask` is 1111 and all banks close. With bit 10 low, only the addressed bank closes and `bankMask` is one-hot.
- R8: `cmdError` is high together with the event for a read or write to a closed bank, and for an activate to an open bank. In the second case the bank keeps its row.
- R9: The event appears in the cycle after the edge that sampled the command and lasts one cycle. When no event is produced, every event output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs sampled on the rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; low suppresses decoding |
| csN | input | 1 | Active-low chip select |
| rasN | input | 1 | Active-low row strobe |
| casN | input | 1 | Active-low column strobe |
| weN | input | 1 | Active-low write enable |
| addr | input | 13 | Row address, column address and bit-10 control |
| ba | input | 2 | Bank address |
| cmdValid | output | 1 | One-cycle event strobe |
| cmdType | output | 3 | Decoded command kind |
| bankMask | output | 4 | Banks affected by the event |
| rowAddr | output | 13 | Row for the event |
| colAddr | output | COL_W (9/10/11) | Column for read and write |
| autoPre | output | 1 | Auto-precharge requested |
| cmdError | output | 1 | Bank-state violation |
| openMask | output | 4 | Banks currently holding an open row |

## Verification
A corrupted open flag shows on `openMask` on the clock after the command that set it. It also changes `cmdError` on the next access to that bank. A corrupted stored row only shows when a read or write reaches that bank, because that event carries the stored row on `rowAddr`. For this reason the stimulus follows every activate with an access to the same bank. A wrong decode or a wrong column slice is visible on the very next cycle. All three organizations run in parallel on the same stimulus, so a column-slice fault appears on the same read.

// File: rtl/sdram_dec_pkg.sv
package sdram_dec_pkg;
  localparam int ROW_W   = 13;
  localparam int BANK_W  = 2;
  localparam int N_BANKS = 1 << BANK_W;
  localparam int AP_BIT  = 10;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6
  } cmdType_t;

  typedef struct packed {
    logic               fire;
    cmdType_t           kind;
    logic [N_BANKS-1:0] maskOut;
    logic [N_BANKS-1:0] openSet;
    logic [N_BANKS-1:0] closeSet;
    logic               useAddrRow;
    logic               useStoredRow;
    logic               showCol;
    logic               apOut;
    logic               errOut;
  } ctrlStrobe_t;

  function automatic int colWidth(input int org);
    if (org == 16)     return 9;
    else if (org == 8) return 10;
    else               return 11;
  endfunction
endpackage

// File: rtl/sdram_dec_ctrl.sv
module sdram_dec_ctrl
  import sdram_dec_pkg::*;
(
  input  logic               cke,
  input  logic               csN,
  input  logic               rasN,
  input  logic               casN,
  input  logic               weN,
  input  logic               apBit,
  input  logic [BANK_W-1:0]  ba,
  input  logic [N_BANKS-1:0] openMask,
  output ctrlStrobe_t        strobe
);
  logic [N_BANKS-1:0] bankOh;
  logic               selected;
  logic               bankOpen;

  assign selected = cke && !csN;
  assign bankOpen = openMask[ba];

  always_comb begin
    bankOh = '0;
    for (int i = 0; i < N_BANKS; i++) begin
      if (ba == i[BANK_W-1:0]) bankOh[i] = 1'b1;
    end
  end

  always_comb begin
    strobe = '0;
    strobe.kind = CMD_NOP;
    if (selected) begin
      unique case ({rasN, casN, weN})
        3'b111: begin
          strobe.fire = 1'b1;
          strobe.kind = CMD_NOP;
        end
        3'b011: begin
          strobe.fire       = 1'b1;
          strobe.kind       = CMD_ACT;
          strobe.maskOut    = bankOh;
          strobe.useAddrRow = 1'b1;
          strobe.errOut     = bankOpen;
          strobe.openSet    = bankOpen ? '0 : bankOh;
        end
        3'b101, 3'b100: begin
          strobe.fire         = 1'b1;
          strobe.kind         = weN ? CMD_RD : CMD_WR;
          strobe.maskOut      = bankOh;
          strobe.useStoredRow = 1'b1;
          strobe.showCol      = 1'b1;
          strobe.apOut        = apBit;
          strobe.errOut       = !bankOpen;
          strobe.closeSet     = (apBit && bankOpen) ? bankOh : '0;
        end
        3'b010: begin
          strobe.fire     = 1'b1;
          strobe.kind     = CMD_PRE;
          strobe.maskOut  = apBit ? {N_BANKS{1'b1}} : bankOh;
          strobe.closeSet = apBit ? {N_BANKS{1'b1}} : bankOh;
        end
        3'b001: begin
          strobe.fire = 1'b1;
          strobe.kind = CMD_REF;
        end
        3'b000: begin
          strobe.fire       = 1'b1;
          strobe.kind       = CMD_MRS;
          strobe.useAddrRow = 1'b1;
        end
        default: strobe.fire = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/sdram_dec_datapath.sv
module sdram_dec_datapath
  import sdram_dec_pkg::*;
#(
  parameter int ORG   = 16,
  parameter int COL_W = colWidth(ORG)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ROW_W-1:0]   addr,
  input  logic [BANK_W-1:0]  ba,
  input  ctrlStrobe_t        strobe,
  output logic [N_BANKS-1:0] openMask,
  output logic               cmdValid,
  output logic [2:0]         cmdType,
  output logic [N_BANKS-1:0] bankMask,
  output logic [ROW_W-1:0]   rowAddr,
  output logic [COL_W-1:0]   colAddr,
  output logic               autoPre,
  output logic               cmdError
);
  logic [ROW_W-1:0] rowStore [N_BANKS];
  logic [COL_W-1:0] colSel;
  logic [ROW_W-1:0] rowSel;

  generate
    if (ORG == 16) begin : g_col16
      assign colSel = addr[8:0];
    end else if (ORG == 8) begin : g_col8
      assign colSel = addr[9:0];
    end else begin : g_col4
      assign colSel = {addr[11], addr[9:0]};
    end
  endgenerate

  generate
    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
      always_ff @(posedge clk) begin
        if (!rstN) begin
          openMask[b] <= 1'b0;
          rowStore[b] <= '0;
        end else if (strobe.openSet[b]) begin
          openMask[b] <= 1'b1;
          rowStore[b] <= addr;
        end else if (strobe.closeSet[b]) begin
          openMask[b] <= 1'b0;
          rowStore[b] <= '0;
        end
      end
    end
  endgenerate

  always_comb begin
    if (strobe.useAddrRow)        rowSel = addr;
    else if (strobe.useStoredRow) rowSel = rowStore[ba];
    else                          rowSel = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.fire) begin
      cmdValid <= 1'b0;
      cmdType  <= CMD_NOP;
      bankMask <= '0;
      rowAddr  <= '0;
      colAddr  <= '0;
      autoPre  <= 1'b0;
      cmdError <= 1'b0;
    end else begin
      cmdValid <= 1'b1;
      cmdType  <= strobe.kind;
      bankMask <= strobe.maskOut;
      rowAddr  <= rowSel;
      colAddr  <= strobe.showCol ? colSel : '0;
      autoPre  <= strobe.apOut;
      cmdError <= strobe.errOut;
    end
  end
endmodule

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder
  import sdram_dec_pkg::*;
#(
  parameter int ORG = 16,
  localparam int COL_W = colWidth(ORG)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cke,
  input  logic             csN,
  input  logic             rasN,
  input  logic             casN,
  input  logic             weN,
  input  logic [12:0]      addr,
  input  logic [1:0]       ba,
  output logic             cmdValid,
  output logic [2:0]       cmdType,
  output logic [3:0]       bankMask,
  output logic [12:0]      rowAddr,
  output logic [COL_W-1:0] colAddr,
  output logic             autoPre,
  output logic             cmdError,
  output logic [3:0]       openMask
);
  ctrlStrobe_t strobe;

  sdram_dec_ctrl u_ctrl (
    .cke      (cke),
    .csN      (csN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .apBit    (addr[AP_BIT]),
    .ba       (ba),
    .openMask (openMask),
    .strobe   (strobe)
  );

  sdram_dec_datapath #(.ORG(ORG), .COL_W(COL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .ba       (ba),
    .strobe   (strobe),
    .openMask (openMask),
    .cmdValid (cmdValid),
    .cmdType  (cmdType),
    .bankMask (bankMask),
    .rowAddr  (rowAddr),
    .colAddr  (colAddr),
    .autoPre  (autoPre),
    .cmdError (cmdError)
  );
endmodule

// File: rtl/sdram_dec_checker.sv
module sdram_dec_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cke,
  input logic        csN,
  input logic        rasN,
  input logic        casN,
  input logic        weN,
  input logic [12:0] addr,
  input logic [1:0]  ba,
  input logic        cmdValid,
  input logic [2:0]  cmdType,
  input logic [3:0]  bankMask,
  input logic        autoPre,
  input logic        cmdError,
  input logic [3:0]  openMask
);
  logic takeCmd;
  assign takeCmd = cke && !csN;

  a_r3_idle_no_event: assert property (@(posedge clk) disable iff (!rstN)
    (!cke || csN) |=> !cmdValid);

  a_r3_idle_state_kept: assert property (@(posedge clk) disable iff (!rstN)
    (!cke || csN) |=> $stable(openMask));

  a_r4_activate_opens: assert property (@(posedge clk) disable iff (!rstN)
    (takeCmd && {rasN, casN, weN} == 3'b011) |=> openMask[$past(ba)]);

  a_r7_precharge_all: assert property (@(posedge clk) disable iff (!rstN)
    (takeCmd && {rasN, casN, weN} == 3'b010 && addr[10]) |=> (openMask == 4'b0000));

  a_r6_ap_only_on_access: assert property (@(posedge clk) disable iff (!rstN)
    autoPre |-> (cmdValid && (cmdType == 3'd2 || cmdType == 3'd3)));

  a_r8_error_with_event: assert property (@(posedge clk) disable iff (!rstN)
    cmdError |-> cmdValid);

  a_r9_quiet_outputs: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> (bankMask == 4'b0000 && cmdType == 3'd0));

  a_r7_mask_shape: assert property (@(posedge clk) disable iff (!rstN)
    (bankMask != 4'b1111) |-> $onehot0(bankMask));
endmodule

bind sdram_cmd_decoder sdram_dec_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cke      (cke),
  .csN      (csN),
  .rasN     (rasN),
  .casN     (casN),
  .weN      (weN),
  .addr     (addr),
  .ba       (ba),
  .cmdValid (cmdValid),
  .cmdType  (cmdType),
  .bankMask (bankMask),
  .autoPre  (autoPre),
  .cmdError (cmdError),
  .openMask (openMask)
);

// File: tb/sdram_cmd_decoder_test.sv
module sdram_cmd_decoder_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cke = 1'b1, csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [12:0] addr = '0;
  logic [1:0]  ba = '0;

  logic        cmdValid, autoPre, cmdError;
  logic [2:0]  cmdType;
  logic [3:0]  bankMask, openMask;
  logic [12:0] rowAddr;
  logic [8:0]  colAddr;
  logic [9:0]  colAddr8;
  logic [10:0] colAddr4;
  logic        v8, ap8, e8, v4, ap4, e4;
  logic [2:0]  t8, t4;
  logic [3:0]  m8, o8, m4, o4;
  logic [12:0] r8, r4;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sdram_cmd_decoder uut (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .addr(addr), .ba(ba), .cmdValid(cmdValid), .cmdType(cmdType),
    .bankMask(bankMask), .rowAddr(rowAddr), .colAddr(colAddr), .autoPre(autoPre),
    .cmdError(cmdError), .openMask(openMask)
  );

  sdram_cmd_decoder #(.ORG(8)) uut8 (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .addr(addr), .ba(ba), .cmdValid(v8), .cmdType(t8),
    .bankMask(m8), .rowAddr(r8), .colAddr(colAddr8), .autoPre(ap8),
    .cmdError(e8), .openMask(o8)
  );

  sdram_cmd_decoder #(.ORG(4)) uut4 (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .addr(addr), .ba(ba), .cmdValid(v4), .cmdType(t4),
    .bankMask(m4), .rowAddr(r4), .colAddr(colAddr4), .autoPre(ap4),
    .cmdError(e4), .openMask(o4)
  );

  typedef struct packed {
    bit        ck;
    bit        cs;
    bit [2:0]  rcw;
    bit [1:0]  bk;
    bit [12:0] ad;
    bit        eV;
    bit [2:0]  eT;
    bit [3:0]  eM;
    bit [12:0] eR;
    bit [8:0]  eC;
    bit        eA;
    bit        eE;
    bit [3:0]  eO;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1,0,3'b111,2'd0,13'h0000, 1,3'd0,4'b0000,13'h0000,9'h000,0,0,4'b0000}, // R2 no-op
    '{1,0,3'b011,2'd1,13'h1ABC, 1,3'd1,4'b0010,13'h1ABC,9'h000,0,0,4'b0010}, // R4 activate
    '{1,0,3'b101,2'd1,13'h0123, 1,3'd2,4'b0010,13'h1ABC,9'h123,0,0,4'b0010}, // R5 read
    '{1,0,3'b100,2'd1,13'h005F, 1,3'd3,4'b0010,13'h1ABC,9'h05F,0,0,4'b0010}, // R5 write
    '{1,0,3'b011,2'd1,13'h0005, 1,3'd1,4'b0010,13'h0005,9'h000,0,1,4'b0010}, // R8 act open
    '{1,0,3'b101,2'd2,13'h0011, 1,3'd2,4'b0100,13'h0000,9'h011,0,1,4'b0010}, // R8 read closed
    '{1,1,3'b011,2'd2,13'h0042, 0,3'd0,4'b0000,13'h0000,9'h000,0,0,4'b0010}, // R3 csN high
    '{0,0,3'b011,2'd2,13'h0042, 0,3'd0,4'b0000,13'h0000,9'h000,0,0,4'b0010}, // R3 cke low
    '{1,0,3'b011,2'd3,13'h0777, 1,3'd1,4'b1000,13'h0777,9'h000,0,0,4'b1010}, // R4
    '{1,0,3'b101,2'd3,13'h04FF, 1,3'd2,4'b1000,13'h0777,9'h0FF,1,0,4'b0010}, // R6 read+AP
    '{1,0,3'b010,2'd1,13'h0000, 1,3'd4,4'b0010,13'h0000,9'h000,0,0,4'b0000}, // R7 single
    '{1,0,3'b011,2'd0,13'h1FFF, 1,3'd1,4'b0001,13'h1FFF,9'h000,0,0,4'b0001}, // R4
    '{1,0,3'b011,2'd2,13'h0042, 1,3'd1,4'b0100,13'h0042,9'h000,0,0,4'b0101}, // R4
    '{1,0,3'b010,2'd3,13'h0400, 1,3'd4,4'b1111,13'h0000,9'h000,0,0,4'b0000}, // R7 all
    '{1,0,3'b001,2'd0,13'h0000, 1,3'd5,4'b0000,13'h0000,9'h000,0,0,4'b0000}, // R2 refresh
    '{1,0,3'b000,2'd0,13'h0033, 1,3'd6,4'b0000,13'h0033,9'h000,0,0,4'b0000}, // R2 mode set
    '{1,0,3'b110,2'd0,13'h0000, 0,3'd0,4'b0000,13'h0000,9'h000,0,0,4'b0000}, // R2 110 ignored
    '{1,0,3'b011,2'd0,13'h0001, 1,3'd1,4'b0001,13'h0001,9'h000,0,0,4'b0001}, // R4
    '{1,0,3'b100,2'd0,13'h05AA, 1,3'd3,4'b0001,13'h0001,9'h1AA,1,0,4'b0000}  // R6 write+AP
  };

  task automatic drive(input bit ck, input bit cs, input bit [2:0] rcw,
                       input bit [1:0] bk, input bit [12:0] ad);
    @(negedge clk);
    cke = ck; csN = cs; {rasN, casN, weN} = rcw; ba = bk; addr = ad;
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #5;
    chk("R1", "cmdValid", cmdValid, 0);
    chk("R1", "openMask", openMask, 0);
    chk("R1", "rowAddr", rowAddr, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #5;
    chk("R1", "cmdValid after release", cmdValid, 0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].ck, VECS[i].cs, VECS[i].rcw, VECS[i].bk, VECS[i].ad);
      chk("R9", $sformatf("v%0d cmdValid", i), cmdValid, VECS[i].eV);
      chk("R2", $sformatf("v%0d cmdType", i), cmdType, VECS[i].eT);
      chk("R7", $sformatf("v%0d bankMask", i), bankMask, VECS[i].eM);
      chk("R4", $sformatf("v%0d rowAddr", i), rowAddr, VECS[i].eR);
      chk("R5", $sformatf("v%0d colAddr", i), colAddr, VECS[i].eC);
      chk("R6", $sformatf("v%0d autoPre", i), autoPre, VECS[i].eA);
      chk("R8", $sformatf("v%0d cmdError", i), cmdError, VECS[i].eE);
      chk("R3", $sformatf("v%0d openMask", i), openMask, VECS[i].eO);
    end

    // R9: one-cycle event, then quiet on a 110 pattern
    drive(1, 0, 3'b110, 2'd0, 13'h0000);
    chk("R9", "pulse ended", cmdValid, 0);
    chk("R9", "quiet rowAddr", rowAddr, 0);

    // R5: column slice per organization
    drive(1, 0, 3'b011, 2'd2, 13'h0005);
    drive(1, 0, 3'b101, 2'd2, 13'h0A01);
    chk("R5", "x16 col", colAddr, 13'h001);
    chk("R5", "x8 col", colAddr8, 13'h201);
    chk("R5", "x4 col", colAddr4, 13'h601);
    chk("R5", "x4 row", r4, 13'h0005);
    chk("R6", "A10 low keeps open", openMask, 4'b0100);

    // R1: reset in mid-run closes banks
    drive(1, 0, 3'b011, 2'd3, 13'h0100);
    chk("R4", "open before reset", openMask, 4'b1100);
    @(negedge clk);
    rstN = 1'b0;
    cke = 1'b1; csN = 1'b1;
    @(posedge clk);
    #5;
    chk("R1", "openMask after reset", openMask, 0);
    @(negedge clk);
    rstN = 1'b1;
    drive(1, 0, 3'b101, 2'd3, 13'h0000);
    chk("R1", "stored row cleared", rowAddr, 0);
    chk("R8", "closed after reset", cmdError, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule